// File: doc/BRIEF.md
# Clock Synthesizer Configuration Port over I2C

This block is the two-wire control port of a programmable clock synthesizer. It answers as an I2C target on a shared bus and keeps eight 8-bit configuration registers. The 64 register bits go out in parallel to the synthesizer's divider and mode logic. The SCL and SDA inputs arrive already conditioned. A short flop chain, whose depth is a parameter, brings them into the system clock domain. A faster system clock then oversamples both lines to find bus conditions and SCL edges. The block drives the shared SDA line through a single open-drain enable.

A bus host sends a register-index byte and then any number of data bytes to write a burst. To read, it sets the index the same way, issues a repeated START and fetches bytes from that index onward. Each accepted data byte moves the index forward by one. The index wraps inside the eight registers. A configuration byte takes effect when the block acknowledges it, not when the transfer ends, so the synthesizer sees the settings change one byte at a time. Two strap pins set the low address bits, which lets four of these blocks share one bus.

Top module: `cfg_i2c_regfile`

## Requirements
- R1: The block acknowledges only the 7-bit address whose upper five bits are 10110 and whose low two bits equal strap_i[1:0]. Any other address is left unacknowledged, and the block keeps SDA released and ignores all bytes until the next START.
- R2: The all-zero general-call address is never acknowledged, and data that follows it changes no register.
- R3: In the first byte after an address with R/W=0, bits [2:0] choose the register index. Bits [7:3] are ignored. This byte is acknowledged.
- R4: Each complete data byte is written to the indexed register on the SCL falling edge that ends its eighth bit, which is when the acknowledge starts. This happens before any STOP, and the write is then acknowledged.
- R5: After every complete data byte, written or read, the index goes up by one and wraps from 7 to 0. Bytes beyond eight in a burst overwrite registers from the start again.
- R6: If a STOP or a repeated START arrives partway through a data byte, the bits received so far are dropped. No register changes and the index does not move.
- R7: After a repeated START and the own address with R/W=1, the block sends the register at the index MSB first, then the following registers in order, wrapping as needed, for as long as the host acknowledges.
- R8: When the host leaves a read byte unacknowledged, the block releases SDA and drives nothing more until the next START.
- R9: Every register bit resets to zero and reads back exactly as written. Register k appears on cfg_o bits 8k+7 down to 8k.
- R10: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. After a STOP the block answers nothing until a new START. SDA is released or driven only after an SCL falling edge or a bus condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level, as seen on the wire |
| strap_i | input | 2 | Low bits of the target address, from strap pins |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_o | output | 64 | All configuration registers, register k in bits 8k+7:8k |

## Verification
Some rules are checked at every clock. An acknowledge is only given to the block's own non-zero address. The line is released whenever the target is idle. Registers and the SDA enable change only after an SCL falling edge or a bus condition. Every write moves the index by exactly one. Other behaviour shows only across whole transfers and is left to the bench scenarios: the values read back after wrap-around, a partial byte being dropped when the transfer is cut short, silence after a STOP or a host NACK, and bits [7:3] of the index byte having no effect.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

   // Protocol position of the target engine
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_REG,
      ST_REG_ACK,
      ST_WDAT,
      ST_WDAT_ACK,
      ST_RDAT,
      ST_RDAT_ACK
   } slv_state_e;

   // Single-cycle bus events derived from the oversampled lines
   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
      logic fall;
      logic sda;
   } bus_evt_t;

endpackage

// File: rtl/cfg_i2c_linemon.sv
module cfg_i2c_linemon
   import cfg_i2c_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_i,
   input  logic     sda_i,
   output bus_evt_t evt_o
);

   logic scl_s, sda_s;
   logic scl_q, sda_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign scl_s = scl_i;
         assign sda_s = sda_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe <= '1;
               sda_pipe <= '1;
            end else begin
               scl_pipe <= (scl_pipe << 1) | SYNC_STAGES'(scl_i);
               sda_pipe <= (sda_pipe << 1) | SYNC_STAGES'(sda_i);
            end
         end
         assign scl_s = scl_pipe[SYNC_STAGES-1];
         assign sda_s = sda_pipe[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   // SDA moving while SCL stays high is a bus condition
   assign evt_o.start = scl_q & scl_s & sda_q & ~sda_s;
   assign evt_o.stop  = scl_q & scl_s & ~sda_q & sda_s;
   assign evt_o.rise  = ~scl_q & scl_s;
   assign evt_o.fall  = scl_q & ~scl_s;
   assign evt_o.sda   = sda_s;

endmodule

// File: rtl/cfg_i2c_bank.sv
module cfg_i2c_bank #(
   parameter int NUM_REGS = 8,
   parameter int DATA_W   = 8,
   parameter int PTR_W    = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [PTR_W-1:0]           ptr,
   input  logic [DATA_W-1:0]          wdata,
   output logic [DATA_W-1:0]          rdata,
   output logic [NUM_REGS*DATA_W-1:0] cfg_o
);

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (wr_en && ptr == PTR_W'(i))
               q <= wdata;
         end
         assign cfg_o[i*DATA_W +: DATA_W] = q;
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int k = 0; k < NUM_REGS; k++)
         if (ptr == PTR_W'(k))
            rdata = cfg_o[k*DATA_W +: DATA_W];
   end

endmodule

// File: rtl/cfg_i2c_engine.sv
module cfg_i2c_engine
   import cfg_i2c_pkg::*;
#(
   parameter int         DATA_W   = 8,
   parameter int         PTR_W    = 3,
   parameter int         STRAP_W  = 2,
   parameter logic [6:0] DEV_BASE = 7'b1011000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  bus_evt_t           evt,
   input  logic [STRAP_W-1:0] strap,
   input  logic [DATA_W-1:0]  rd_data,
   output logic               wr_en,
   output logic [DATA_W-1:0]  wr_data,
   output logic [PTR_W-1:0]   ptr_o,
   output slv_state_e         st_o,
   output logic [DATA_W-1:0]  sh_o,
   output logic               sda_oe_o
);

   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   slv_state_e         st;
   logic [DATA_W-1:0]  sh, tx;
   logic [CNT_W-1:0]   cnt;
   logic [PTR_W-1:0]   ptr;
   logic               rw, mack;
   logic [6:0]         own_addr;
   logic               byte_done;

   assign own_addr  = {DEV_BASE[6:STRAP_W], strap};
   assign byte_done = evt.fall && (cnt == FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         sh   <= '0;
         tx   <= '0;
         cnt  <= '0;
         ptr  <= '0;
         rw   <= 1'b0;
         mack <= 1'b0;
      end else if (evt.stop) begin
         st <= ST_IDLE;
      end else if (evt.start) begin
         st  <= ST_DEV;
         cnt <= '0;
      end else begin
         case (st)
            ST_DEV, ST_REG, ST_WDAT: begin
               if (evt.rise && cnt != FULL) begin
                  sh  <= {sh[DATA_W-2:0], evt.sda};
                  cnt <= cnt + 1'b1;
               end else if (byte_done) begin
                  if (st == ST_DEV) begin
                     if (sh[7:1] == own_addr) begin
                        st <= ST_DEV_ACK;
                        rw <= sh[0];
                     end else begin
                        st <= ST_IDLE;
                     end
                  end else if (st == ST_REG) begin
                     ptr <= sh[PTR_W-1:0];
                     st  <= ST_REG_ACK;
                  end else begin
                     ptr <= ptr + 1'b1;
                     st  <= ST_WDAT_ACK;
                  end
               end
            end
            ST_DEV_ACK: begin
               if (evt.fall) begin
                  cnt <= '0;
                  if (rw) begin
                     st <= ST_RDAT;
                     tx <= rd_data;
                  end else begin
                     st <= ST_REG;
                  end
               end
            end
            ST_REG_ACK, ST_WDAT_ACK: begin
               if (evt.fall) begin
                  cnt <= '0;
                  st  <= ST_WDAT;
               end
            end
            ST_RDAT: begin
               if (evt.fall) begin
                  tx  <= {tx[DATA_W-2:0], 1'b0};
                  cnt <= cnt + 1'b1;
                  if (cnt == LAST) begin
                     st  <= ST_RDAT_ACK;
                     ptr <= ptr + 1'b1;
                  end
               end
            end
            ST_RDAT_ACK: begin
               if (evt.rise)
                  mack <= ~evt.sda;
               else if (evt.fall) begin
                  if (mack) begin
                     st  <= ST_RDAT;
                     tx  <= rd_data;
                     cnt <= '0;
                  end else begin
                     st <= ST_IDLE;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign wr_en   = (st == ST_WDAT) && byte_done && !evt.start && !evt.stop;
   assign wr_data = sh;

   always_comb begin
      case (st)
         ST_DEV_ACK, ST_REG_ACK, ST_WDAT_ACK: sda_oe_o = 1'b1;
         ST_RDAT:                             sda_oe_o = ~tx[DATA_W-1];
         default:                             sda_oe_o = 1'b0;
      endcase
   end

   assign ptr_o = ptr;
   assign st_o  = st;
   assign sh_o  = sh;

endmodule

// File: rtl/cfg_i2c_regfile.sv
module cfg_i2c_regfile
   import cfg_i2c_pkg::*;
#(
   parameter int         NUM_REGS    = 8,
   parameter int         DATA_W      = 8,
   parameter int         STRAP_W     = 2,
   parameter logic [6:0] DEV_BASE    = 7'b1011000,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       scl_i,
   input  logic                       sda_i,
   input  logic [STRAP_W-1:0]         strap_i,
   output logic                       sda_oe_o,
   output logic [NUM_REGS*DATA_W-1:0] cfg_o
);

   localparam int PTR_W = $clog2(NUM_REGS);
   localparam int CFG_W = NUM_REGS * DATA_W;

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("cfg_i2c_regfile: bus bytes are 8 bits, DATA_W must be 8");
      end
      if (NUM_REGS < 2 || (1 << PTR_W) != NUM_REGS) begin : g_bad_depth
         $error("cfg_i2c_regfile: NUM_REGS must be a power of two of at least 2");
      end
      if (STRAP_W < 1 || STRAP_W > 3) begin : g_bad_strap
         $error("cfg_i2c_regfile: STRAP_W must lie between 1 and 3");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("cfg_i2c_regfile: SYNC_STAGES cannot be negative");
      end
   endgenerate

   bus_evt_t          evt;
   slv_state_e        st;
   logic [PTR_W-1:0]  ptr;
   logic [DATA_W-1:0] sh, wr_data, rd_data;
   logic              wr_en;

   cfg_i2c_linemon #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_mon (
      .clk  (clk),
      .rst_n(rst_n),
      .scl_i(scl_i),
      .sda_i(sda_i),
      .evt_o(evt)
   );

   cfg_i2c_engine #(
      .DATA_W  (DATA_W),
      .PTR_W   (PTR_W),
      .STRAP_W (STRAP_W),
      .DEV_BASE(DEV_BASE)
   ) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt),
      .strap   (strap_i),
      .rd_data (rd_data),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .ptr_o   (ptr),
      .st_o    (st),
      .sh_o    (sh),
      .sda_oe_o(sda_oe_o)
   );

   cfg_i2c_bank #(
      .NUM_REGS(NUM_REGS),
      .DATA_W  (DATA_W),
      .PTR_W   (PTR_W)
   ) u_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_en(wr_en),
      .ptr  (ptr),
      .wdata(wr_data),
      .rdata(rd_data),
      .cfg_o(cfg_o)
   );

endmodule

// File: rtl/cfg_i2c_checker.sv
module cfg_i2c_checker
   import cfg_i2c_pkg::*;
#(
   parameter int         PTR_W    = 3,
   parameter int         STRAP_W  = 2,
   parameter logic [6:0] DEV_BASE = 7'b1011000,
   parameter int         CFG_W    = 64
) (
   input logic               clk,
   input logic               rst_n,
   input bus_evt_t           evt,
   input logic [STRAP_W-1:0] strap,
   input slv_state_e         st,
   input logic [PTR_W-1:0]   ptr,
   input logic [7:0]         sh,
   input logic               wr_en,
   input logic               sda_oe,
   input logic [CFG_W-1:0]   cfg
);

   logic [6:0] own_addr;
   assign own_addr = {DEV_BASE[6:STRAP_W], strap};

   // R1: an address acknowledge is only ever given to the own address
   p_ack_own_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DEV_ACK) |-> (sh[7:1] == own_addr));

   // R1: nothing is driven while the target is idle
   p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_oe);

   // R2: the general-call address never reaches acknowledge
   p_no_gcall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DEV_ACK) |-> (sh[7:1] != 7'd0));

   // R4: register contents only move on an SCL falling edge
   p_cfg_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !evt.fall |=> $stable(cfg));

   // R5: every committed byte advances the index by one, with wrap
   p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

   // R8: after the host's acknowledge slot the target either continues or lets go
   p_nack_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RDAT_ACK && evt.fall && !evt.start && !evt.stop)
         |=> (st == ST_RDAT || !sda_oe));

   // R10: the SDA enable moves only after a falling SCL edge or a bus condition
   p_sda_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt.fall && !evt.start && !evt.stop) |=> $stable(sda_oe));

endmodule

bind cfg_i2c_regfile cfg_i2c_checker #(
   .PTR_W   (PTR_W),
   .STRAP_W (STRAP_W),
   .DEV_BASE(DEV_BASE),
   .CFG_W   (CFG_W)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .evt   (evt),
   .strap (strap_i),
   .st    (st),
   .ptr   (ptr),
   .sh    (sh),
   .wr_en (wr_en),
   .sda_oe(sda_oe_o),
   .cfg   (cfg_o)
);

// File: tb/sim_cfg_i2c_regfile.sv
module sim_cfg_i2c_regfile;

   localparam int Q = 6;  // system clocks per quarter bus bit

   logic        clk   = 1'b0;
   logic        rst_n = 1'b0;
   logic        m_scl = 1'b1;
   logic        m_sda = 1'b1;
   logic [1:0]  strap = 2'b01;
   logic        sda_line;
   logic        sda_oe;
   logic [63:0] cfg;

   int     nvec = 0;
   int     nerr = 0;
   longint cyc  = 0;
   bit     done = 1'b0;

   logic [7:0] mreg [8];
   int         mptr = 0;

   always #4 clk = ~clk;

   assign sda_line = m_sda & ~sda_oe;

   cfg_i2c_regfile u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_i   (m_scl),
      .sda_i   (sda_line),
      .strap_i (strap),
      .sda_oe_o(sda_oe),
      .cfg_o   (cfg)
   );

   function automatic logic [63:0] mflat();
      logic [63:0] v;
      for (int k = 0; k < 8; k++) v[k*8 +: 8] = mreg[k];
      return v;
   endfunction

   function automatic logic [7:0] own(input bit rd);
      return {5'b10110, strap, rd};
   endfunction

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      nvec++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; wq();
      m_scl = 1'b1; wq();
      m_sda = 1'b0; wq();
      m_scl = 1'b0; wq();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wq();
      m_scl = 1'b1; wq();
      m_sda = 1'b1; wq();
   endtask

   task automatic put_bit(input bit b);
      m_sda = b;    wq();
      m_scl = 1'b1; wq(); wq();
      m_scl = 1'b0; wq();
   endtask

   task automatic get_bit(output bit b);
      m_sda = 1'b1; wq();
      m_scl = 1'b1; wq();
      b = sda_line; wq();
      m_scl = 1'b0; wq();
   endtask

   task automatic put_byte(input logic [7:0] d, output bit ack);
      bit b;
      for (int i = 7; i >= 0; i--) put_bit(d[i]);
      get_bit(b);
      ack = !b;
   endtask

   task automatic get_byte(output logic [7:0] d, input bit ack);
      bit b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         d[i] = b;
      end
      put_bit(!ack);
   endtask

   task automatic wr_burst(input logic [7:0] ra, input int n);
      bit a;
      logic [7:0] d;
      bus_start();
      put_byte(own(1'b0), a);
      chk(a, "R1", "own address ack", {63'd0, a}, 64'd1);
      put_byte(ra, a);
      chk(a, "R3", "index byte ack", {63'd0, a}, 64'd1);
      mptr = int'(ra[2:0]);
      for (int i = 0; i < n; i++) begin
         d = 8'($urandom);
         put_byte(d, a);
         chk(a, "R4", "data ack", {63'd0, a}, 64'd1);
         mreg[mptr] = d;
         mptr = (mptr + 1) % 8;
         chk(cfg == mflat(), "R4", "commit before STOP", cfg, mflat());
      end
      bus_stop();
      chk(cfg == mflat(), "R5", "burst with wrap", cfg, mflat());
   endtask

   task automatic rd_burst(input logic [7:0] ra, input int n);
      bit a, b, low_seen;
      logic [7:0] d;
      bus_start();
      put_byte(own(1'b0), a);
      chk(a, "R1", "own address ack", {63'd0, a}, 64'd1);
      put_byte(ra, a);
      chk(a, "R3", "index byte ack", {63'd0, a}, 64'd1);
      mptr = int'(ra[2:0]);
      bus_start();
      put_byte(own(1'b1), a);
      chk(a, "R7", "read address ack", {63'd0, a}, 64'd1);
      for (int i = 0; i < n; i++) begin
         get_byte(d, i != n - 1);
         chk(d == mreg[mptr], "R7", "read byte", {56'd0, d}, {56'd0, mreg[mptr]});
         mptr = (mptr + 1) % 8;
      end
      chk(!sda_oe, "R8", "released after NACK", {63'd0, sda_oe}, 64'd0);
      low_seen = 1'b0;
      for (int i = 0; i < 9; i++) begin
         get_bit(b);
         if (!b) low_seen = 1'b1;
      end
      chk(!low_seen, "R8", "silent after NACK", {63'd0, low_seen}, 64'd0);
      bus_stop();
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000 && !done) begin
         done = 1'b1;
         nvec++;
         nerr++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         report();
      end
   end

   initial begin
      bit a;
      logic [7:0] d;
      void'($urandom(32'h1c0ffee5));
      for (int k = 0; k < 8; k++) mreg[k] = 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R9: reset value
      chk(cfg == 64'd0, "R9", "reset state", cfg, 64'd0);

      // R1: foreign address (other strap value) with trailing bytes
      bus_start();
      put_byte({5'b10110, ~strap, 1'b0}, a);
      chk(!a, "R1", "foreign address nack", {63'd0, a}, 64'd0);
      put_byte(8'h02, a);
      chk(!a, "R1", "foreign index ignored", {63'd0, a}, 64'd0);
      put_byte(8'hFF, a);
      chk(!a, "R1", "foreign data ignored", {63'd0, a}, 64'd0);
      bus_stop();
      chk(cfg == mflat(), "R1", "no change after foreign", cfg, mflat());

      // R2: general call
      bus_start();
      put_byte(8'h00, a);
      chk(!a, "R2", "general call nack", {63'd0, a}, 64'd0);
      put_byte(8'h01, a);
      put_byte(8'hA5, a);
      chk(!a, "R2", "general call data nack", {63'd0, a}, 64'd0);
      bus_stop();
      chk(cfg == mflat(), "R2", "no change after general call", cfg, mflat());

      // R5: eleven bytes from index 6 with high index bits set (R3)
      wr_burst(8'hF6, 11);
      rd_burst(8'h05, 10);

      // R10: own address after STOP without a new START
      put_byte(own(1'b0), a);
      chk(!a, "R10", "no answer without START", {63'd0, a}, 64'd0);
      put_byte(8'h44, a);
      bus_stop();
      chk(cfg == mflat(), "R10", "no change without START", cfg, mflat());

      // R6: STOP after five bits of a data byte
      bus_start();
      put_byte(own(1'b0), a);
      put_byte(8'h03, a);
      put_byte(8'h5A, a);
      mreg[3] = 8'h5A;
      for (int i = 0; i < 5; i++) put_bit(1'b1);
      bus_stop();
      chk(cfg == mflat(), "R6", "partial byte dropped at STOP", cfg, mflat());

      // R6: repeated START after three bits, index must not have moved
      bus_start();
      put_byte(own(1'b0), a);
      put_byte(8'h06, a);
      put_byte(8'hC3, a);
      mreg[6] = 8'hC3;
      put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
      bus_start();
      put_byte(own(1'b1), a);
      get_byte(d, 1'b0);
      chk(d == mreg[7], "R6", "index held after repeated START", {56'd0, d}, {56'd0, mreg[7]});
      bus_stop();
      chk(cfg == mflat(), "R6", "registers after abort", cfg, mflat());

      // R1: new strap value, the old address is no longer answered
      strap = 2'b10;
      repeat (4) @(negedge clk);
      bus_start();
      put_byte({5'b10110, 2'b01, 1'b0}, a);
      chk(!a, "R1", "old strap address nack", {63'd0, a}, 64'd0);
      bus_stop();
      wr_burst(8'h00, 8);
      rd_burst(8'h00, 8);

      // R9: constrained-random bursts, every bit read back
      for (int it = 0; it < 18; it++) begin
         if (($urandom % 5) == 0) begin
            strap = 2'($urandom);
            repeat (4) @(negedge clk);
         end
         if ($urandom % 2)
            wr_burst(8'($urandom), 1 + int'($urandom % 12));
         else
            rd_burst(8'($urandom), 1 + int'($urandom % 10));
      end
      rd_burst(8'h00, 8);
      chk(cfg == mflat(), "R9", "final register image", cfg, mflat());

      done = 1'b1;
      report();
   end

endmodule